// File: doc/BRIEF.md
# Taskfile Register-Pair Sequencer

This block takes the command part of a packet held in memory and turns it into a stream of writes on a disk-controller taskfile port. A packet starts with a 16-byte header. The header holds a response byte, a flag byte and a length byte, followed by two pointers and a reserved word, none of which this block uses. After the header comes a list of two-byte entries. Each entry is a register value followed by an address byte. The address byte holds the taskfile register number and two in-band flags: one makes the block skip the write, the other marks the last entry. The block streams the entries in order and issues at most one taskfile write per clock. It stops at the entry marked last. It then writes a completion code into byte 0 of the packet.

Memory is read 16 bits at a time and is little-endian: byte 2k of the packet is the low byte of halfword k, and byte 2k+1 is the high byte. The packet base is given in halfword units. A single-cycle `start` begins a packet. `done` marks the one cycle in which the response byte is written. The length byte L says the packet spans (L+2)*8 bytes. That leaves room for at most 4*L entries after the header.

Top module: `tf_pair_seq`

## Requirements
- R1: After reset, `busy`, `done`, `tf_we`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: The header flag byte is packet byte 2 (low byte of halfword 1). Bit 0 of that byte means valid, bit 2 means a data phase follows, and bit 3 means interrupt enable. Bits 2 and 3 appear on `data_phase` and `irq_en` while `done` is high.
- R3: Entries start at packet byte 16 (halfword 8). In each entry the value is the low byte and the address byte is the high byte. Every entry that is not skipped produces exactly one write with `tf_addr` equal to address-byte bits 4:0 and `tf_data` equal to the value. Writes come out in packet order, and repeated addresses are written again, as in 48-bit command setup.
- R4: An entry whose address byte has bit 5 set produces no taskfile write.
- R5: An entry whose address byte has bit 7 set is the last one processed. It is still written unless bit 5 is also set. The response byte is then written as 0x01.
- R6: A packet whose valid bit is clear produces no taskfile writes. Its response byte is 0x02.
- R7: The length byte is packet byte 3. A valid packet with length 0 produces no writes and response 0x04.
- R8: If none of the first 4*L entries carries the end flag, those 4*L entries are processed and the response is 0x08. No entry beyond them is processed.
- R9: Entries that are not skipped and follow one another produce taskfile writes on consecutive clock cycles.
- R10: A `start` pulse while `busy` is high is ignored. The running packet finishes with exactly one `done`.
- R11: `done` lasts one cycle per packet. In that cycle `mem_wr_en` is high, `mem_wr_addr` equals the packet base, and `ok` is high exactly when the response is 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin processing the packet at `pkt_base` |
| pkt_base | input | AW | Packet base address in halfwords |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Halfword read address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Response byte write strobe |
| mem_wr_addr | output | AW | Halfword address for the response write (low byte) |
| mem_wr_data | output | 8 | Response code |
| tf_we | output | 1 | Taskfile write strobe |
| tf_addr | output | 5 | Taskfile register number |
| tf_data | output | 8 | Taskfile write value |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | Completion cycle |
| ok | output | 1 | Completion was successful |
| data_phase | output | 1 | Header data-phase flag |
| irq_en | output | 1 | Header interrupt-enable flag |

## Verification
When the end-flagged entry is written, that taskfile write and the response-byte write fall in the same cycle. A bug can easily drop or delay one of them. Every packet that ends on a written entry provokes this case. The bench checks that the final write appears in the write log and that exactly one response is recorded, with the expected code, in the `done` cycle. A separate directed packet ends on an entry that is both skipped and end-flagged. It confirms that the response is written without the last taskfile write.

// File: rtl/tf_pair_seq.sv
module tf_pair_seq #(
  parameter int AW   = 16,
  parameter int LENW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] pkt_base,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [15:0]   mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic          tf_we,
  output logic [4:0]    tf_addr,
  output logic [7:0]    tf_data,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          data_phase,
  output logic          irq_en
);
  localparam int CW = LENW + 2;
  localparam logic [7:0] RC_OK    = 8'h01;
  localparam logic [7:0] RC_INVAL = 8'h02;
  localparam logic [7:0] RC_ZLEN  = 8'h04;
  localparam logic [7:0] RC_OVER  = 8'h08;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_RUN, S_RESP} st_t;
  st_t st;

  logic [AW-1:0] base_q;
  logic [CW-1:0] iss_q, arr_q, lim_q;
  logic          rvalid_q;
  logic [7:0]    code_q;
  logic          dp_q, ie_q;
  logic          we_q;
  logic [4:0]    ta_q;
  logic [7:0]    td_q;

  wire            hdr_vld   = mem_rd_data[0];
  wire [LENW-1:0] hdr_len   = mem_rd_data[8 +: LENW];
  wire            hdr_go    = hdr_vld && (hdr_len != '0);
  wire            pair_end  = mem_rd_data[15];
  wire            pair_skip = mem_rd_data[13];
  wire            last_slot = (arr_q == lim_q - CW'(1));
  wire            run_stop  = rvalid_q && (pair_end || last_slot);

  always_comb begin
    mem_rd_en   = 1'b0;
    mem_rd_addr = base_q + AW'(8) + AW'(iss_q);
    case (st)
      S_IDLE: begin
        mem_rd_en   = start;
        mem_rd_addr = pkt_base + AW'(1);
      end
      S_HDR: begin
        mem_rd_en   = hdr_go;
        mem_rd_addr = base_q + AW'(8);
      end
      S_RUN:  mem_rd_en = (iss_q < lim_q) && !run_stop;
      default: mem_rd_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_q   <= '0;
      iss_q    <= '0;
      arr_q    <= '0;
      lim_q    <= '0;
      rvalid_q <= 1'b0;
      code_q   <= '0;
      dp_q     <= 1'b0;
      ie_q     <= 1'b0;
      we_q     <= 1'b0;
      ta_q     <= '0;
      td_q     <= '0;
    end else begin
      we_q     <= 1'b0;
      rvalid_q <= mem_rd_en && (st == S_HDR || st == S_RUN);
      case (st)
        S_IDLE: if (start) begin
          base_q <= pkt_base;
          st     <= S_HDR;
        end
        S_HDR: begin
          dp_q  <= mem_rd_data[2];
          ie_q  <= mem_rd_data[3];
          lim_q <= {hdr_len, 2'b00};
          iss_q <= CW'(1);
          arr_q <= '0;
          if (!hdr_vld) begin
            code_q <= RC_INVAL;
            st     <= S_RESP;
          end else if (hdr_len == '0) begin
            code_q <= RC_ZLEN;
            st     <= S_RESP;
          end else begin
            st <= S_RUN;
          end
        end
        S_RUN: begin
          if (mem_rd_en) iss_q <= iss_q + CW'(1);
          if (rvalid_q) begin
            arr_q <= arr_q + CW'(1);
            we_q  <= !pair_skip;
            ta_q  <= mem_rd_data[12:8];
            td_q  <= mem_rd_data[7:0];
            if (pair_end) begin
              code_q <= RC_OK;
              st     <= S_RESP;
            end else if (last_slot) begin
              code_q <= RC_OVER;
              st     <= S_RESP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_RESP);
  assign mem_wr_en   = done;
  assign mem_wr_addr = base_q;
  assign mem_wr_data = code_q;
  assign ok          = done && (code_q == RC_OK);
  assign tf_we       = we_q;
  assign tf_addr     = ta_q;
  assign tf_data     = td_q;
  assign data_phase  = dp_q;
  assign irq_en      = ie_q;
endmodule

// File: rtl/tf_pair_seq_chk.sv
module tf_pair_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_wr_addr,
  input logic [7:0]    mem_wr_data,
  input logic          tf_we,
  input logic          busy,
  input logic          done,
  input logic          ok
);
  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R11
  resp_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wr_data == 8'h01) == ok));
  // R3
  tf_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tf_we |-> busy);
  // R10
  rd_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (busy || start));
  // R11
  resp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_wr_en && mem_wr_data != 8'h00));
  // R5
  resp_stable_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_wr_addr));
endmodule

bind tf_pair_seq tf_pair_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tf_pair_seq_tb.sv
module tf_pair_seq_tb;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] pkt_base = '0;
  logic mem_rd_en, mem_wr_en, tf_we, busy, done, ok, data_phase, irq_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [15:0] mem_rd_data;
  logic [7:0] mem_wr_data, tf_data;
  logic [4:0] tf_addr;

  always #5 clk = ~clk;

  tf_pair_seq #(.AW(AW), .LENW(8)) u_dut (.*);

  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
    if (mem_wr_en) mem[mem_wr_addr[7:0]][7:0] <= mem_wr_data;
  end

  int checks = 0, errors = 0, cyc = 0;
  int n_got = 0, n_done = 0;
  logic [4:0] g_a [0:63];
  logic [7:0] g_d [0:63];
  int g_c [0:63];
  logic [7:0] r_code;
  logic r_ok, r_dp, r_ie;
  logic [AW-1:0] r_addr;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (tf_we && n_got < 64) begin
        g_a[n_got] = tf_addr; g_d[n_got] = tf_data; g_c[n_got] = cyc; n_got++;
      end
      if (done) begin
        r_code = mem_wr_data; r_ok = ok; r_dp = data_phase; r_ie = irq_en;
        r_addr = mem_wr_addr; n_done++;
      end
    end
  end

  task automatic chk(input bit c, input string req, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [4:0] e_a [0:63];
  logic [7:0] e_d [0:63];
  int n_exp;
  logic [7:0] e_code;
  bit e_skip;

  task automatic model(input int b);
    logic [15:0] h;
    int lim;
    h = mem[(b + 1) & 255];
    n_exp = 0; e_skip = 0;
    if (!h[0]) e_code = 8'h02;
    else if (h[15:8] == 0) e_code = 8'h04;
    else begin
      lim = 4 * h[15:8];
      e_code = 8'h08;
      for (int k = 0; k < lim; k++) begin
        logic [15:0] p;
        p = mem[(b + 8 + k) & 255];
        if (p[13]) e_skip = 1;
        else begin e_a[n_exp] = p[12:8]; e_d[n_exp] = p[7:0]; n_exp++; end
        if (p[15]) begin e_code = 8'h01; break; end
      end
    end
  endtask

  task automatic put_hdr(input int b, input logic [7:0] fl, input logic [7:0] len);
    mem[b & 255] = 16'h0000;
    mem[(b + 1) & 255] = {len, fl};
    for (int k = 2; k < 8; k++) mem[(b + k) & 255] = 16'h5a5a;
  endtask

  task automatic put_pair(input int b, input int k, input logic [7:0] v, input logic [7:0] a);
    mem[(b + 8 + k) & 255] = {a, v};
  endtask

  task automatic run(input int b, input bit dbl, input string tag);
    bit [7:0] fl;
    fl = mem[(b + 1) & 255][7:0];
    model(b);
    n_got = 0; n_done = 0;
    @(negedge clk); start = 1; pkt_base = AW'(b);
    @(negedge clk); start = 0;
    if (dbl) begin
      @(negedge clk); @(negedge clk);
      start = 1; pkt_base = AW'((b + 64) & 255);
      @(negedge clk); start = 0;
    end
    for (int t = 0; t < 300 && n_done == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_done == 1, "R11 done count", n_done, 1);
    chk(r_code == e_code, {tag, " response code"}, r_code, e_code);
    chk(r_ok == (e_code == 8'h01), "R11 ok", r_ok, e_code == 8'h01);
    chk(r_addr == AW'(b), "R11 response address", r_addr, b);
    chk(mem[b & 255][7:0] == e_code, "R11 response byte in memory", mem[b & 255][7:0], e_code);
    chk(r_dp == fl[2] && r_ie == fl[3], "R2 header flags", {r_dp, r_ie}, {fl[2], fl[3]});
    chk(n_got == n_exp, {tag, " R3 R4 write count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk(g_a[i] == e_a[i] && g_d[i] == e_d[i], "R3 write content",
          {g_a[i], g_d[i]}, {e_a[i], e_d[i]});
    if (!e_skip)
      for (int i = 1; i < n_got; i++)
        chk(g_c[i] == g_c[i-1] + 1, "R9 back-to-back writes", g_c[i] - g_c[i-1], 1);
  endtask

  localparam logic [7:0] TFA [0:6] = '{8'h0e, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 16'h8000;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tf_we && !mem_rd_en && !mem_wr_en, "R1 reset state",
        {busy, done, tf_we, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R5 48-bit style ordering with a skipped entry before the command
    put_hdr(0, 8'h0d, 8'd4);
    put_pair(0, 0, 8'he0, 8'h16);
    put_pair(0, 1, 8'h01, 8'h12); put_pair(0, 2, 8'h11, 8'h13);
    put_pair(0, 3, 8'h22, 8'h14); put_pair(0, 4, 8'h33, 8'h15);
    put_pair(0, 5, 8'h08, 8'h12); put_pair(0, 6, 8'h44, 8'h13);
    put_pair(0, 7, 8'h55, 8'h14); put_pair(0, 8, 8'h66, 8'h15);
    put_pair(0, 9, 8'h00, 8'h0e); put_pair(0, 10, 8'h00, 8'h20);
    put_pair(0, 11, 8'h25, 8'h97);
    run(0, 0, "R5");

    // R6 invalid packet
    put_hdr(64, 8'h0c, 8'd2);
    put_pair(64, 0, 8'h77, 8'h97);
    run(64, 0, "R6");

    // R7 zero length
    put_hdr(128, 8'h01, 8'd0);
    put_pair(128, 0, 8'h77, 8'h97);
    run(128, 0, "R7");

    // R8 overrun: four entries without end, end entry just beyond
    put_hdr(0, 8'h01, 8'd1);
    for (int k = 0; k < 4; k++) put_pair(0, k, 8'(k + 1), 8'h13);
    put_pair(0, 4, 8'hee, 8'h97);
    run(0, 0, "R8");

    // R4 R5 end flag on a skipped entry
    put_hdr(64, 8'h05, 8'd1);
    put_pair(64, 0, 8'h31, 8'h14);
    put_pair(64, 1, 8'h32, 8'ha0);
    run(64, 0, "R5");

    // R10 start while busy
    put_hdr(0, 8'h09, 8'd2);
    for (int k = 0; k < 6; k++) put_pair(0, k, 8'(8'h40 + k), TFA[k]);
    put_pair(0, 6, 8'hc8, 8'h97);
    put_hdr(64, 8'h01, 8'd1);
    put_pair(64, 0, 8'h99, 8'h97);
    run(0, 1, "R10");

    for (int it = 0; it < 40; it++) begin
      int n, len, b;
      b = (it % 2) ? 128 : 32;
      n = 1 + $urandom % 12;
      len = (n + 3) / 4 + $urandom % 2;
      put_hdr(b, 8'($urandom) | 8'h01, 8'(len));
      for (int k = 0; k < n; k++) begin
        logic [7:0] a;
        a = TFA[$urandom % 7];
        if ($urandom % 4 == 0) a = a | 8'h20;
        if (k == n - 1) a = a | 8'h80;
        put_pair(b, k, 8'($urandom), a);
      end
      run(b, 0, "R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule